// File: doc/BRIEF.md
# DRAM ECC Error Capture and Injection Registers

This block sits next to the ECC checker of a DRAM controller. The checker sends it single-bit, multi-bit and other error pulses for each read access, together with the 64-bit data word, the 8-bit check byte and the 36-bit address of that access. The block keeps a sticky flag for each error kind. It counts correctable errors against a programmable threshold, and it freezes a snapshot of the first failing access until software acknowledges it. An interrupt line is high while any enabled flag is set.

The same register port holds three injection registers. When injection is armed, the controller's write path passes its outgoing data word and check byte through this block, and the block XORs the programmed masks into them. Software can then provoke known errors on a later read. Register reads are combinational from the address. Writes take effect on the clock edge where the write enable is high.

Register word indices: 0 flags, 1 cause mask, 2 interrupt enables, 3 correctable-error control, 4 captured data upper, 5 captured data lower, 6 captured check byte, 7 captured address lower, 8 captured address upper bits, 9 inject mask upper, 10 inject mask lower, 11 inject control. Unlisted indices read as zero.

Top module: `dram_ecc_errlog`

## Requirements
- R1: Flag register bit 0 is correctable (single-bit), bit 1 is uncorrectable (multi-bit) and bit 2 is other. A flag sets on the clock edge that samples its qualifying event and then stays set.
- R2: Writing the flag register clears each flag whose write-data bit is 1. If an event sets a flag in the same cycle as a clearing write, the flag ends up set.
- R3: Cause-mask register bits 2:0 use the same positions as the flag register. A cause whose mask bit is 1 never sets its flag, never advances the counter and never loads the capture registers.
- R4: Correctable-error control bits 23:16 hold a threshold T. If T is 0, every unmasked single-bit event sets flag bit 0. Otherwise each unmasked single-bit event advances the count in bits 7:0. The event that brings the count to T sets flag bit 0 and returns the count to 0.
- R5: Writing the correctable-error control register loads T from write-data bits 23:16 and sets the count to 0. Reading it returns T in bits 23:16 and the count in bits 7:0.
- R6: The capture registers load only when an event sets a flag while all flags were clear in the previous state. They hold their value while any flag is set.
- R7: The captures hold the data word (bits 63:32 and bits 31:0 in separate registers), the check byte in bits 7:0, address bits 31:0, and the upper address bits right-aligned in their own register.
- R8: Interrupt-enable bit 0 gates flag 0 and bit 1 gates flag 1. The irq output is 1 exactly while some flag is set together with its enable.
- R9: Inject-control bit 8 arms injection. When armed, the data output is the data input XOR {upper mask, lower mask} and the check output is the check input XOR control bits 7:0. When not armed, both outputs equal their inputs.
- R10: After reset, every register reads 0 and irq is 0.
- R11: The two inject mask registers read back all 32 written bits. Inject control reads back bits 8:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 4 | Register word index |
| reg_wr_en | input | 1 | Write strobe |
| reg_wr_data | input | 32 | Write data |
| reg_rd_data | output | 32 | Read data for reg_addr |
| ev_sbe | input | 1 | Single-bit error pulse |
| ev_mbe | input | 1 | Multi-bit error pulse |
| ev_other | input | 1 | Other error cause pulse |
| ev_data | input | 64 | Data word of the failing access |
| ev_ecc | input | 8 | Check byte of the failing access |
| ev_addr | input | 36 | Address of the failing access |
| wp_data_in | input | 64 | Write-path data before injection |
| wp_ecc_in | input | 8 | Write-path check byte before injection |
| wp_data_out | output | 64 | Write-path data after injection |
| wp_ecc_out | output | 8 | Write-path check byte after injection |
| irq | output | 1 | Error interrupt |

## Verification
The bench uses the default parameters: a 36-bit address and an 8-bit threshold. The address width puts four bits into the upper capture register, so the right-alignment of those bits is visible at the port. Thresholds of 0 and 3 are programmed. The value 3 lets the bench watch the count rise below the threshold, the flag set at the threshold, and a control write reset a partial count. Same-cycle set-and-clear, masked causes and a partially enabled interrupt are each driven directly.

// File: rtl/ecc_errlog_pkg.sv
package ecc_errlog_pkg;

    localparam int REG_W      = 32;
    localparam int REG_AW     = 4;
    localparam int NUM_FLAGS  = 3;
    localparam int NUM_IRQ    = 2;
    localparam int THR_LSB    = 16;
    localparam int INJ_EN_BIT = 8;

    localparam int F_SBE = 0;
    localparam int F_MBE = 1;
    localparam int F_OTH = 2;

    typedef enum logic [REG_AW-1:0] {
        RA_FLAGS    = 4'd0,
        RA_MASK     = 4'd1,
        RA_IRQEN    = 4'd2,
        RA_SBECTL   = 4'd3,
        RA_CAP_DHI  = 4'd4,
        RA_CAP_DLO  = 4'd5,
        RA_CAP_ECC  = 4'd6,
        RA_CAP_ALO  = 4'd7,
        RA_CAP_AHI  = 4'd8,
        RA_INJ_HI   = 4'd9,
        RA_INJ_LO   = 4'd10,
        RA_INJ_CTL  = 4'd11
    } reg_idx_e;

    typedef struct packed {
        logic flags;
        logic mask;
        logic irqen;
        logic sbectl;
        logic inj_hi;
        logic inj_lo;
        logic inj_ctl;
    } wr_strobe_t;

    function automatic wr_strobe_t decode_write(input logic en, input logic [REG_AW-1:0] idx);
        wr_strobe_t s;
        s.flags   = en && (idx == RA_FLAGS);
        s.mask    = en && (idx == RA_MASK);
        s.irqen   = en && (idx == RA_IRQEN);
        s.sbectl  = en && (idx == RA_SBECTL);
        s.inj_hi  = en && (idx == RA_INJ_HI);
        s.inj_lo  = en && (idx == RA_INJ_LO);
        s.inj_ctl = en && (idx == RA_INJ_CTL);
        return s;
    endfunction

endpackage

// File: rtl/errlog_flags.sv
module errlog_flags
    import ecc_errlog_pkg::*;
#(
    parameter int THR_W = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 ev_sbe,
    input  logic                 ev_mbe,
    input  logic                 ev_other,
    input  logic                 wr_flags,
    input  logic                 wr_mask,
    input  logic                 wr_irqen,
    input  logic                 wr_sbectl,
    input  logic [NUM_FLAGS-1:0] wdata_flags,
    input  logic [THR_W-1:0]     wdata_thr,
    output logic [NUM_FLAGS-1:0] flags,
    output logic [NUM_FLAGS-1:0] cause_mask,
    output logic [NUM_IRQ-1:0]   irq_en,
    output logic [THR_W-1:0]     thr,
    output logic [THR_W-1:0]     sbe_cnt,
    output logic [NUM_FLAGS-1:0] set_now,
    output logic                 irq
);

    logic             sbe_live;
    logic [THR_W:0]   cnt_inc;
    logic             sbe_reached;
    logic [NUM_FLAGS-1:0] clr_bits;

    always_comb begin
        sbe_live    = ev_sbe && !cause_mask[F_SBE];
        cnt_inc     = {1'b0, sbe_cnt} + 1'b1;
        sbe_reached = (thr == '0) || (cnt_inc >= {1'b0, thr});
        set_now         = '0;
        set_now[F_SBE]  = sbe_live && sbe_reached;
        set_now[F_MBE]  = ev_mbe   && !cause_mask[F_MBE];
        set_now[F_OTH]  = ev_other && !cause_mask[F_OTH];
        clr_bits        = wr_flags ? wdata_flags : '0;
        irq             = |(flags[NUM_IRQ-1:0] & irq_en);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags      <= '0;
            cause_mask <= '0;
            irq_en     <= '0;
            thr        <= '0;
            sbe_cnt    <= '0;
        end else begin
            flags <= (flags & ~clr_bits) | set_now;
            if (wr_mask)  cause_mask <= wdata_flags;
            if (wr_irqen) irq_en     <= wdata_flags[NUM_IRQ-1:0];
            if (wr_sbectl) begin
                thr     <= wdata_thr;
                sbe_cnt <= '0;
            end else if (sbe_live) begin
                sbe_cnt <= sbe_reached ? '0 : cnt_inc[THR_W-1:0];
            end
        end
    end

    assert_mbe_sticky_R1: assert property (@(posedge clk) disable iff (rst)
        (ev_mbe && !cause_mask[F_MBE]) |=> flags[F_MBE]);

    assert_w1c_R2: assert property (@(posedge clk) disable iff (rst)
        (wr_flags && wdata_flags[F_MBE] && !(ev_mbe && !cause_mask[F_MBE])) |=> !flags[F_MBE]);

    assert_masked_cause_R3: assert property (@(posedge clk) disable iff (rst)
        (cause_mask[F_OTH] && !flags[F_OTH]) |=> !flags[F_OTH]);

    assert_cnt_below_thr_R4: assert property (@(posedge clk) disable iff (rst)
        (thr != '0) |-> (sbe_cnt < thr));

endmodule

// File: rtl/errlog_capture.sv
module errlog_capture #(
    parameter int DATA_W = 64,
    parameter int ECC_W  = 8,
    parameter int ADDR_W = 36
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              any_set,
    input  logic              flags_clear,
    input  logic [DATA_W-1:0] ev_data,
    input  logic [ECC_W-1:0]  ev_ecc,
    input  logic [ADDR_W-1:0] ev_addr,
    output logic [DATA_W-1:0] cap_data,
    output logic [ECC_W-1:0]  cap_ecc,
    output logic [ADDR_W-1:0] cap_addr
);

    logic load;
    assign load = any_set && flags_clear;

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_data <= '0;
            cap_ecc  <= '0;
            cap_addr <= '0;
        end else if (load) begin
            cap_data <= ev_data;
            cap_ecc  <= ev_ecc;
            cap_addr <= ev_addr;
        end
    end

    assert_capture_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !flags_clear |=> ($stable(cap_data) && $stable(cap_ecc) && $stable(cap_addr)));

endmodule

// File: rtl/errlog_inject.sv
module errlog_inject
    import ecc_errlog_pkg::*;
#(
    parameter int ECC_W = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_hi,
    input  logic                 wr_lo,
    input  logic                 wr_ctl,
    input  logic [REG_W-1:0]     wdata,
    input  logic [2*REG_W-1:0]   data_in,
    input  logic [ECC_W-1:0]     ecc_in,
    output logic [REG_W-1:0]     mask_hi,
    output logic [REG_W-1:0]     mask_lo,
    output logic [INJ_EN_BIT:0]  ctl,
    output logic [2*REG_W-1:0]   data_out,
    output logic [ECC_W-1:0]     ecc_out
);

    logic armed;
    assign armed = ctl[INJ_EN_BIT];

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_hi <= '0;
            mask_lo <= '0;
            ctl     <= '0;
        end else begin
            if (wr_hi)  mask_hi <= wdata;
            if (wr_lo)  mask_lo <= wdata;
            if (wr_ctl) ctl     <= wdata[INJ_EN_BIT:0];
        end
    end

    always_comb begin
        data_out = data_in;
        ecc_out  = ecc_in;
        if (armed) begin
            data_out = data_in ^ {mask_hi, mask_lo};
            ecc_out  = ecc_in ^ ctl[ECC_W-1:0];
        end
    end

    assert_mask_hi_load_R11: assert property (@(posedge clk) disable iff (rst)
        wr_hi |=> (mask_hi == $past(wdata)));

endmodule

// File: rtl/dram_ecc_errlog.sv
module dram_ecc_errlog
    import ecc_errlog_pkg::*;
#(
    parameter int ADDR_W = 36,
    parameter int ECC_W  = 8,
    parameter int THR_W  = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [REG_AW-1:0]    reg_addr,
    input  logic                 reg_wr_en,
    input  logic [REG_W-1:0]     reg_wr_data,
    output logic [REG_W-1:0]     reg_rd_data,
    input  logic                 ev_sbe,
    input  logic                 ev_mbe,
    input  logic                 ev_other,
    input  logic [2*REG_W-1:0]   ev_data,
    input  logic [ECC_W-1:0]     ev_ecc,
    input  logic [ADDR_W-1:0]    ev_addr,
    input  logic [2*REG_W-1:0]   wp_data_in,
    input  logic [ECC_W-1:0]     wp_ecc_in,
    output logic [2*REG_W-1:0]   wp_data_out,
    output logic [ECC_W-1:0]     wp_ecc_out,
    output logic                 irq
);

    localparam int DATA_W = 2 * REG_W;
    localparam int EXT_W  = ADDR_W - REG_W;

    wr_strobe_t            wr;
    logic [NUM_FLAGS-1:0]  flags, cause_mask, set_now;
    logic [NUM_IRQ-1:0]    irq_en;
    logic [THR_W-1:0]      thr, sbe_cnt;
    logic [DATA_W-1:0]     cap_data;
    logic [ECC_W-1:0]      cap_ecc;
    logic [ADDR_W-1:0]     cap_addr;
    logic [REG_W-1:0]      mask_hi, mask_lo;
    logic [INJ_EN_BIT:0]   inj_ctl;

    assign wr = decode_write(reg_wr_en, reg_addr);

    errlog_flags #(.THR_W(THR_W)) u_flags (
        .clk         (clk),
        .rst         (rst),
        .ev_sbe      (ev_sbe),
        .ev_mbe      (ev_mbe),
        .ev_other    (ev_other),
        .wr_flags    (wr.flags),
        .wr_mask     (wr.mask),
        .wr_irqen    (wr.irqen),
        .wr_sbectl   (wr.sbectl),
        .wdata_flags (reg_wr_data[NUM_FLAGS-1:0]),
        .wdata_thr   (reg_wr_data[THR_LSB +: THR_W]),
        .flags       (flags),
        .cause_mask  (cause_mask),
        .irq_en      (irq_en),
        .thr         (thr),
        .sbe_cnt     (sbe_cnt),
        .set_now     (set_now),
        .irq         (irq)
    );

    errlog_capture #(.DATA_W(DATA_W), .ECC_W(ECC_W), .ADDR_W(ADDR_W)) u_capture (
        .clk         (clk),
        .rst         (rst),
        .any_set     (|set_now),
        .flags_clear (flags == '0),
        .ev_data     (ev_data),
        .ev_ecc      (ev_ecc),
        .ev_addr     (ev_addr),
        .cap_data    (cap_data),
        .cap_ecc     (cap_ecc),
        .cap_addr    (cap_addr)
    );

    errlog_inject #(.ECC_W(ECC_W)) u_inject (
        .clk      (clk),
        .rst      (rst),
        .wr_hi    (wr.inj_hi),
        .wr_lo    (wr.inj_lo),
        .wr_ctl   (wr.inj_ctl),
        .wdata    (reg_wr_data),
        .data_in  (wp_data_in),
        .ecc_in   (wp_ecc_in),
        .mask_hi  (mask_hi),
        .mask_lo  (mask_lo),
        .ctl      (inj_ctl),
        .data_out (wp_data_out),
        .ecc_out  (wp_ecc_out)
    );

    always_comb begin
        reg_rd_data = '0;
        case (reg_addr)
            RA_FLAGS:   reg_rd_data[NUM_FLAGS-1:0] = flags;
            RA_MASK:    reg_rd_data[NUM_FLAGS-1:0] = cause_mask;
            RA_IRQEN:   reg_rd_data[NUM_IRQ-1:0]   = irq_en;
            RA_SBECTL: begin
                reg_rd_data[THR_LSB +: THR_W] = thr;
                reg_rd_data[THR_W-1:0]        = sbe_cnt;
            end
            RA_CAP_DHI: reg_rd_data = cap_data[DATA_W-1:REG_W];
            RA_CAP_DLO: reg_rd_data = cap_data[REG_W-1:0];
            RA_CAP_ECC: reg_rd_data[ECC_W-1:0] = cap_ecc;
            RA_CAP_ALO: reg_rd_data = cap_addr[REG_W-1:0];
            RA_CAP_AHI: reg_rd_data[EXT_W-1:0] = cap_addr[ADDR_W-1:REG_W];
            RA_INJ_HI:  reg_rd_data = mask_hi;
            RA_INJ_LO:  reg_rd_data = mask_lo;
            RA_INJ_CTL: reg_rd_data[INJ_EN_BIT:0] = inj_ctl;
            default:    reg_rd_data = '0;
        endcase
    end

    assert_irq_needs_flag_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> (flags != '0));

endmodule

// File: tb/dram_ecc_errlog_tb.sv
module dram_ecc_errlog_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic [3:0]  reg_addr;
    logic        reg_wr_en;
    logic [31:0] reg_wr_data;
    logic [31:0] reg_rd_data;
    logic        ev_sbe, ev_mbe, ev_other;
    logic [63:0] ev_data;
    logic [7:0]  ev_ecc;
    logic [35:0] ev_addr;
    logic [63:0] wp_data_in, wp_data_out;
    logic [7:0]  wp_ecc_in, wp_ecc_out;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    dram_ecc_errlog u_dut (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr_en(reg_wr_en),
        .reg_wr_data(reg_wr_data), .reg_rd_data(reg_rd_data),
        .ev_sbe(ev_sbe), .ev_mbe(ev_mbe), .ev_other(ev_other),
        .ev_data(ev_data), .ev_ecc(ev_ecc), .ev_addr(ev_addr),
        .wp_data_in(wp_data_in), .wp_ecc_in(wp_ecc_in),
        .wp_data_out(wp_data_out), .wp_ecc_out(wp_ecc_out), .irq(irq)
    );

    typedef struct packed {
        logic [63:0] din;
        logic [7:0]  ein;
        logic [31:0] mhi;
        logic [31:0] mlo;
        logic [8:0]  ctl;
    } inj_vec_t;

    localparam inj_vec_t VEC [0:5] = '{
        '{64'h0123_4567_89AB_CDEF, 8'h5A, 32'h0000_0001, 32'h8000_0000, 9'h100},
        '{64'hFFFF_FFFF_FFFF_FFFF, 8'hFF, 32'hDEAD_BEEF, 32'h1234_5678, 9'h1C3},
        '{64'h0000_0000_0000_0000, 8'h00, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 9'h0FF},
        '{64'hA5A5_5A5A_0F0F_F0F0, 8'h3C, 32'h0000_0000, 32'h0000_0004, 9'h101},
        '{64'h1111_2222_3333_4444, 8'h81, 32'h8000_0001, 32'h0000_0000, 9'h180},
        '{64'hCAFE_F00D_0BAD_BEEF, 8'h77, 32'h7FFF_FFFE, 32'hAAAA_5555, 9'h000}
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic wr_reg(input logic [3:0] a, input logic [31:0] d);
        reg_addr = a; reg_wr_data = d; reg_wr_en = 1'b1;
        tick();
        reg_wr_en = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [3:0] a, input logic [31:0] exp);
        reg_addr = a;
        #1;
        chk(req, {32'h0, reg_rd_data}, {32'h0, exp});
    endtask

    task automatic pulse(input logic s, input logic m, input logic o,
                         input logic [63:0] d, input logic [7:0] e, input logic [35:0] a);
        ev_sbe = s; ev_mbe = m; ev_other = o; ev_data = d; ev_ecc = e; ev_addr = a;
        tick();
        ev_sbe = 1'b0; ev_mbe = 1'b0; ev_other = 1'b0;
    endtask

    initial begin
        #(8 * 100000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        rst = 1'b1; reg_addr = '0; reg_wr_en = 1'b0; reg_wr_data = '0;
        ev_sbe = 1'b0; ev_mbe = 1'b0; ev_other = 1'b0;
        ev_data = '0; ev_ecc = '0; ev_addr = '0;
        wp_data_in = '0; wp_ecc_in = '0;
        repeat (3) tick();
        rst = 1'b0;
        tick();

        // R10: reset state
        for (int i = 0; i < 12; i++) rd_chk("R10 reset value", i[3:0], 32'h0);
        chk("R10 irq after reset", {63'h0, irq}, 64'h0);

        // R9 / R11: vector table walk
        for (int v = 0; v < 6; v++) begin
            wr_reg(4'd9,  VEC[v].mhi);
            wr_reg(4'd10, VEC[v].mlo);
            wr_reg(4'd11, {23'h0, VEC[v].ctl});
            rd_chk("R11 mask hi readback", 4'd9, VEC[v].mhi);
            rd_chk("R11 mask lo readback", 4'd10, VEC[v].mlo);
            rd_chk("R11 ctl readback", 4'd11, {23'h0, VEC[v].ctl});
            wp_data_in = VEC[v].din; wp_ecc_in = VEC[v].ein;
            #1;
            if (VEC[v].ctl[8]) begin
                chk("R9 data inject", wp_data_out, VEC[v].din ^ {VEC[v].mhi, VEC[v].mlo});
                chk("R9 ecc inject", {56'h0, wp_ecc_out}, {56'h0, VEC[v].ein ^ VEC[v].ctl[7:0]});
            end else begin
                chk("R9 data passthrough", wp_data_out, VEC[v].din);
                chk("R9 ecc passthrough", {56'h0, wp_ecc_out}, {56'h0, VEC[v].ein});
            end
        end

        // R1, R6, R7, R8: first multi-bit error captured
        wr_reg(4'd2, 32'h3);
        pulse(0, 1, 0, 64'hAAAA_BBBB_CCCC_DDDD, 8'hE1, 36'hF_1234_5678);
        rd_chk("R1 mbe flag bit1", 4'd0, 32'h2);
        chk("R8 irq on mbe", {63'h0, irq}, 64'h1);
        rd_chk("R7 cap data hi", 4'd4, 32'hAAAA_BBBB);
        rd_chk("R7 cap data lo", 4'd5, 32'hCCCC_DDDD);
        rd_chk("R7 cap ecc", 4'd6, 32'hE1);
        rd_chk("R7 cap addr lo", 4'd7, 32'h1234_5678);
        rd_chk("R7 cap addr ext", 4'd8, 32'hF);

        // R6: second error leaves capture
        pulse(0, 1, 0, 64'h1111_1111_2222_2222, 8'h02, 36'h3_0000_0000);
        rd_chk("R6 capture held lo", 4'd5, 32'hCCCC_DDDD);
        rd_chk("R6 capture held ext", 4'd8, 32'hF);

        // R2: write one to clear
        wr_reg(4'd0, 32'h2);
        rd_chk("R2 w1c clears", 4'd0, 32'h0);
        chk("R8 irq drops", {63'h0, irq}, 64'h0);

        // R4, R5: threshold 3
        wr_reg(4'd3, 32'h0003_0000);
        rd_chk("R5 threshold readback", 4'd3, 32'h0003_0000);
        pulse(1, 0, 0, 64'h0, 8'h0, 36'h0);
        pulse(1, 0, 0, 64'h0, 8'h0, 36'h0);
        rd_chk("R4 count below threshold", 4'd3, 32'h0003_0002);
        rd_chk("R4 no flag below threshold", 4'd0, 32'h0);
        pulse(1, 0, 0, 64'h0000_0000_5555_6666, 8'h10, 36'h0_0000_0040);
        rd_chk("R4 flag at threshold", 4'd0, 32'h1);
        rd_chk("R4 count returns to zero", 4'd3, 32'h0003_0000);
        rd_chk("R6 capture on sbe flag", 4'd5, 32'h5555_6666);
        chk("R8 irq on sbe", {63'h0, irq}, 64'h1);

        // R5: control write clears partial count
        wr_reg(4'd0, 32'h7);
        pulse(1, 0, 0, 64'h0, 8'h0, 36'h0);
        rd_chk("R4 partial count", 4'd3, 32'h0003_0001);
        wr_reg(4'd3, 32'h0003_0000);
        rd_chk("R5 write resets count", 4'd3, 32'h0003_0000);

        // R4: threshold zero flags immediately
        wr_reg(4'd3, 32'h0);
        pulse(1, 0, 0, 64'h0000_0000_7777_8888, 8'h20, 36'h0);
        rd_chk("R4 threshold zero flags", 4'd0, 32'h1);

        // R3: masked cause
        wr_reg(4'd0, 32'h7);
        wr_reg(4'd1, 32'h2);
        rd_chk("R3 mask readback", 4'd1, 32'h2);
        pulse(0, 1, 0, 64'h0000_0000_9999_0000, 8'h30, 36'h0);
        rd_chk("R3 masked mbe no flag", 4'd0, 32'h0);
        rd_chk("R3 masked mbe no capture", 4'd5, 32'h7777_8888);
        chk("R3 masked mbe no irq", {63'h0, irq}, 64'h0);
        wr_reg(4'd1, 32'h0);

        // R2 / R1: set wins over simultaneous clear, other cause
        ev_other = 1'b1;
        wr_reg(4'd0, 32'h4);
        ev_other = 1'b0;
        rd_chk("R2 set wins over clear / R1 other flag", 4'd0, 32'h4);
        chk("R8 other cause not interrupting", {63'h0, irq}, 64'h0);

        // R8: partial enable
        wr_reg(4'd0, 32'h7);
        wr_reg(4'd2, 32'h1);
        pulse(0, 1, 0, 64'h0, 8'h0, 36'h0);
        rd_chk("R1 mbe flag again", 4'd0, 32'h2);
        chk("R8 mbe disabled no irq", {63'h0, irq}, 64'h0);
        pulse(1, 0, 0, 64'h0, 8'h0, 36'h0);
        chk("R8 sbe enabled irq", {63'h0, irq}, 64'h1);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule